// File: doc/BRIEF.md
# Shared Copy-Back Cache Miss Controller

This block sits in front of external memory and serves several masters, four processors and one DMA port by default, from one shared set-associative cache. The cache has four ways, a parameterized number of sets and lines of eight 32-bit words. It keeps a valid bit and a dirty bit for each line. Stores that hit stay in the cache. Loads and stores that miss both bring the whole line in from memory.

Only one miss is handled at a time. While a fill or a writeback runs, any request that hits in the cache is still accepted and answered. Requests that miss are held back until the running miss has finished. The replacement policy sits outside the block: it supplies the way to replace on the `victimWay` input. The block uses that input only when every way of the set is valid.

Top module: `shared_cb_cache`

## Requirements
- R1: After reset every line is invalid, no grant, response or memory request is active, and the first access to any address misses.
- R2: A request that hits is granted in the cycle it is presented, and its response (`rspValid` plus read data, or the store data echoed back for a store) appears exactly one cycle later, with no memory activity.
- R3: A store that hits writes only its word in the cache and marks the line dirty. A later load of that word returns the stored value.
- R4: A load miss requests the line at `memLine` with `memWrite` low and takes exactly eight beats. Beat k carries word k of the line (word offset = word address bits [2:0]). The response returns the requested word one cycle after the cycle that follows the last beat.
- R5: A store miss fills the whole line from memory, then writes the store word over the filled data and marks the line dirty. The other words keep the values from memory.
- R6: If the chosen victim is valid and dirty, its eight words are written back in word order, with `memWrite` high and the victim's line address, before the fill burst starts.
- R7: The victim is the lowest-numbered invalid way of the set. Only when all four ways are valid is the way on `victimWay` used.
- R8: At most one miss is in progress. A master that misses while a miss is running is not granted until the running miss has delivered its response.
- R9: While a miss is in progress, a request from another master that hits is granted and answered with the one-cycle latency of R2.
- R10: At most one request is granted per cycle. Among the requests eligible in a cycle (all of them when no miss runs, only the hitting ones otherwise), the lowest master index wins, so master 0 comes first and the DMA port (highest index) comes last.
- R11: A request to the line that is being filled is not granted before the fill has completed. It is then served as a hit that returns the filled data.
- R12: `memReq` rises only in the cycle after a miss was accepted, and it stays low while only hits are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | NM | Request per master, held until granted |
| reqWrite | input | NM | 1 = store, 0 = load, per master |
| reqAddr | input | NM x AW | Word address per master |
| reqWData | input | NM x 32 | Store data per master |
| reqGrant | output | NM | One-hot acceptance of a request, combinational |
| rspValid | output | NM | One-cycle response pulse per master |
| rspData | output | NM x 32 | Load data (or echoed store data) per master |
| victimWay | input | 2 | Replacement way from external LRU logic |
| memReq | output | 1 | Burst in progress towards memory |
| memWrite | output | 1 | 1 = writeback burst, 0 = fill burst |
| memLine | output | AW-3 | Line address of the burst |
| memWData | output | 32 | Writeback word for the current beat |
| memBeat | input | 1 | Memory moves one word in this cycle |
| memRData | input | 32 | Fill word for the current beat |

## Verification
A grant is combinational, so the bench reads `reqGrant` one nanosecond after the falling edge at which it drove the request. A hit response is registered at the next rising edge and is read at the falling edge that follows, so the bench expects a latency of exactly one cycle for every hit, including hits accepted during a miss. A miss response comes one cycle after the cycle that follows the last fill beat. The bench therefore does not expect a fixed miss latency. It compares grant cycles against response cycles to check ordering, and it counts and logs memory beats to check burst order, burst length and writeback content.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 8;
  localparam int BEAT_W     = $clog2(LINE_WORDS);

  // Strobes from the miss/grant control into the array datapath
  typedef struct packed {
    logic              hitAcc;    // a hitting request is accepted this cycle
    logic              missAcc;   // a missing request opens the miss slot
    logic              wbPhase;   // writeback burst running
    logic              fillBeat;  // fill word present on memRData
    logic [BEAT_W-1:0] beat;      // word index of the current burst beat
    logic              missDone;  // fill finished, install line and answer
  } ctlStrobe_t;
endpackage

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
#(
  parameter  int NM    = 5,
  localparam int SEL_W = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NM-1:0]    reqValid,
  input  logic [NM-1:0]    hitVec,
  input  logic             victimDirty,
  input  logic             memBeat,
  output logic [NM-1:0]    reqGrant,
  output logic [SEL_W-1:0] selNum,
  output logic             memReq,
  output logic             memWrite,
  output ctlStrobe_t       strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL, ST_DONE} missSt_t;

  missSt_t           state, stateNxt;
  logic [BEAT_W-1:0] beatCnt;
  logic [NM-1:0]     cand;
  logic              busy, found, lastBeat, hitAcc, missAcc;

  // Grant selection: all requesters when idle, only hitting ones during a miss
  always_comb begin
    busy   = (state != ST_IDLE);
    cand   = busy ? (reqValid & hitVec) : reqValid;
    found  = 1'b0;
    selNum = '0;
    for (int i = NM - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found  = 1'b1;
        selNum = SEL_W'(i);
      end
    end
    reqGrant = '0;
    if (found) reqGrant[selNum] = 1'b1;
  end

  assign hitAcc   = found && hitVec[selNum];
  assign missAcc  = found && !hitVec[selNum];
  assign lastBeat = memBeat && (beatCnt == BEAT_W'(LINE_WORDS - 1));

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (missAcc)  stateNxt = victimDirty ? ST_WB : ST_FILL;
      ST_WB:   if (lastBeat) stateNxt = ST_FILL;
      ST_FILL: if (lastBeat) stateNxt = ST_DONE;
      ST_DONE:               stateNxt = ST_IDLE;
      default:               stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      state <= stateNxt;
      if (memReq && memBeat) beatCnt <= lastBeat ? '0 : beatCnt + 1'b1;
    end
  end

  assign memReq   = (state == ST_WB) || (state == ST_FILL);
  assign memWrite = (state == ST_WB);

  assign strb.hitAcc   = hitAcc;
  assign strb.missAcc  = missAcc;
  assign strb.wbPhase  = (state == ST_WB);
  assign strb.fillBeat = (state == ST_FILL) && memBeat;
  assign strb.beat     = beatCnt;
  assign strb.missDone = (state == ST_DONE);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqGrant)); // R10
  AST_MEM_AFTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(strb.missAcc)); // R12
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memReq) |-> ($past(memBeat) && $past(beatCnt) == BEAT_W'(LINE_WORDS - 1))); // R4
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWrite) |-> memReq); // R6
endmodule

// File: rtl/cbc_datapath.sv
module cbc_datapath
  import cbc_pkg::*;
#(
  parameter  int NM    = 5,
  parameter  int SETS  = 16,
  parameter  int WAYS  = 4,
  parameter  int AW    = 30,
  localparam int SEL_W = (NM > 1) ? $clog2(NM) : 1,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = AW - IDX_W - BEAT_W,
  localparam int LN_W  = AW - BEAT_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NM-1:0]             reqWrite,
  input  logic [NM-1:0][AW-1:0]     reqAddr,
  input  logic [NM-1:0][WORD_W-1:0] reqWData,
  input  logic [WAY_W-1:0]          victimWay,
  input  logic [SEL_W-1:0]          selNum,
  input  ctlStrobe_t                strb,
  input  logic [WORD_W-1:0]         memRData,
  output logic [NM-1:0]             hitVec,
  output logic                      victimDirty,
  output logic [LN_W-1:0]           memLine,
  output logic [WORD_W-1:0]         memWData,
  output logic [NM-1:0]             rspValid,
  output logic [NM-1:0][WORD_W-1:0] rspData
);
  // Cache state
  logic [TAG_W-1:0]  tagArr   [SETS][WAYS];
  logic [WAYS-1:0]   validArr [SETS];
  logic [WAYS-1:0]   dirtyArr [SETS];
  logic [WORD_W-1:0] dataArr  [SETS][WAYS][LINE_WORDS];

  // Per-master lookup results
  logic [IDX_W-1:0]  mIdx    [NM];
  logic [TAG_W-1:0]  mTag    [NM];
  logic [WAYS-1:0]   mWayHit [NM];

  for (genvar m = 0; m < NM; m++) begin : g_lookup
    assign mIdx[m] = reqAddr[m][BEAT_W +: IDX_W];
    assign mTag[m] = reqAddr[m][AW-1 -: TAG_W];
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign mWayHit[m][w] = validArr[mIdx[m]][w] && (tagArr[mIdx[m]][w] == mTag[m]);
    end
    assign hitVec[m] = |mWayHit[m];
  end

  // Selected request: hit way, word and victim way
  logic [IDX_W-1:0]  sIdx;
  logic [WAY_W-1:0]  sWay, vicWay;
  logic [BEAT_W-1:0] sWord;
  logic [WORD_W-1:0] hitWord;
  logic              freeFound;

  always_comb begin
    sIdx  = mIdx[selNum];
    sWord = reqAddr[selNum][BEAT_W-1:0];
    sWay  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (mWayHit[selNum][w]) sWay = WAY_W'(w);
    end
    vicWay    = victimWay;
    freeFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!validArr[sIdx][w] && !freeFound) begin
        vicWay    = WAY_W'(w);
        freeFound = 1'b1;
      end
    end
    victimDirty = validArr[sIdx][vicWay] && dirtyArr[sIdx][vicWay];
    hitWord     = dataArr[sIdx][sWay][sWord];
  end

  // Latched miss context
  logic [IDX_W-1:0]  missIdx;
  logic [WAY_W-1:0]  missWay;
  logic [TAG_W-1:0]  missTag, vicTag;
  logic [BEAT_W-1:0] missWord;
  logic              missWr, missOpen;
  logic [WORD_W-1:0] missData, loadWord;
  logic [SEL_W-1:0]  missMaster;

  assign memLine  = strb.wbPhase ? {vicTag, missIdx} : {missTag, missIdx};
  assign memWData = dataArr[missIdx][missWay][strb.beat];

  // Line status and responses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
      end
      rspValid <= '0;
      rspData  <= '0;
      missOpen <= 1'b0;
    end else begin
      rspValid <= '0;
      if (strb.hitAcc) begin
        if (reqWrite[selNum]) dirtyArr[sIdx][sWay] <= 1'b1;
        rspValid[selNum] <= 1'b1;
        rspData[selNum]  <= reqWrite[selNum] ? reqWData[selNum] : hitWord;
      end
      if (strb.missAcc) begin
        validArr[sIdx][vicWay] <= 1'b0;
        dirtyArr[sIdx][vicWay] <= 1'b0;
        missOpen               <= 1'b1;
      end
      if (strb.missDone) begin
        validArr[missIdx][missWay] <= 1'b1;
        dirtyArr[missIdx][missWay] <= missWr;
        rspValid[missMaster]       <= 1'b1;
        rspData[missMaster]        <= missWr ? missData : loadWord;
        missOpen                   <= 1'b0;
      end
    end
  end

  // Tags, data words and miss context
  always_ff @(posedge clk) begin
    if (strb.hitAcc && reqWrite[selNum]) dataArr[sIdx][sWay][sWord] <= reqWData[selNum];
    if (strb.missAcc) begin
      missIdx    <= sIdx;
      missWay    <= vicWay;
      missTag    <= mTag[selNum];
      vicTag     <= tagArr[sIdx][vicWay];
      missWord   <= sWord;
      missWr     <= reqWrite[selNum];
      missData   <= reqWData[selNum];
      missMaster <= selNum;
    end
    if (strb.fillBeat) begin
      dataArr[missIdx][missWay][strb.beat] <= memRData;
      if (strb.beat == missWord) loadWord <= memRData;
    end
    if (strb.missDone) begin
      tagArr[missIdx][missWay] <= missTag;
      if (missWr) dataArr[missIdx][missWay][missWord] <= missData;
    end
  end

  AST_SINGLE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    strb.missAcc |-> !missOpen); // R8
  AST_HIT_RSP: assert property (@(posedge clk) disable iff (!rstN)
    strb.hitAcc |=> rspValid[$past(selNum)]); // R2
  AST_NO_STALE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (missOpen && strb.hitAcc) |-> !(sIdx == missIdx && sWay == missWay)); // R11
endmodule

// File: rtl/shared_cb_cache.sv
module shared_cb_cache
  import cbc_pkg::*;
#(
  parameter  int NM    = 5,
  parameter  int SETS  = 16,
  parameter  int WAYS  = 4,
  parameter  int AW    = 30,
  localparam int SEL_W = (NM > 1) ? $clog2(NM) : 1,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LN_W  = AW - BEAT_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NM-1:0]             reqValid,
  input  logic [NM-1:0]             reqWrite,
  input  logic [NM-1:0][AW-1:0]     reqAddr,
  input  logic [NM-1:0][WORD_W-1:0] reqWData,
  output logic [NM-1:0]             reqGrant,
  output logic [NM-1:0]             rspValid,
  output logic [NM-1:0][WORD_W-1:0] rspData,
  input  logic [WAY_W-1:0]          victimWay,
  output logic                      memReq,
  output logic                      memWrite,
  output logic [LN_W-1:0]           memLine,
  output logic [WORD_W-1:0]         memWData,
  input  logic                      memBeat,
  input  logic [WORD_W-1:0]         memRData
);
  ctlStrobe_t       strb;
  logic [NM-1:0]    hitVec;
  logic             victimDirty;
  logic [SEL_W-1:0] selNum;

  cbc_ctrl #(.NM(NM)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .hitVec      (hitVec),
    .victimDirty (victimDirty),
    .memBeat     (memBeat),
    .reqGrant    (reqGrant),
    .selNum      (selNum),
    .memReq      (memReq),
    .memWrite    (memWrite),
    .strb        (strb)
  );

  cbc_datapath #(.NM(NM), .SETS(SETS), .WAYS(WAYS), .AW(AW)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWData    (reqWData),
    .victimWay   (victimWay),
    .selNum      (selNum),
    .strb        (strb),
    .memRData    (memRData),
    .hitVec      (hitVec),
    .victimDirty (victimDirty),
    .memLine     (memLine),
    .memWData    (memWData),
    .rspValid    (rspValid),
    .rspData     (rspData)
  );
endmodule

// File: tb/test_shared_cb_cache.sv
`timescale 1ns/1ps
module test_shared_cb_cache;
  localparam int NM = 5;
  localparam int AW = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NM-1:0]         reqValid = '0;
  logic [NM-1:0]         reqWrite = '0;
  logic [NM-1:0][AW-1:0] reqAddr  = '0;
  logic [NM-1:0][31:0]   reqWData = '0;
  logic [NM-1:0]         reqGrant, rspValid;
  logic [NM-1:0][31:0]   rspData;
  logic [1:0]            victimWay = 2'd0;
  logic                  memReq, memWrite;
  logic [AW-4:0]         memLine;
  logic [31:0]           memWData;
  logic                  memBeat = 1'b0;
  logic [31:0]           memRData = '0;

  shared_cb_cache i_shared_cb_cache (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, total = 0;
  bit finished = 1'b0;

  // Memory model: unwritten words read as address ^ 0x5A5A0000
  logic [31:0] memModel [int unsigned];
  bit          memGap = 1'b0, gapTog = 1'b0;
  int          bcnt = 0, logN = 0;
  bit          logWr   [64];
  logic [31:0] logAddr [64];
  logic [31:0] logData [64];

  function automatic logic [31:0] modelRd(input logic [31:0] a);
    return memModel.exists(a) ? memModel[a] : (a ^ 32'h5A5A_0000);
  endfunction

  always @(negedge clk) begin
    logic [31:0] ba;
    if (memReq) begin
      if (memGap) gapTog = ~gapTog;
      if (!memGap || gapTog) begin
        ba = {memLine, 5'b0} + 32'(4 * bcnt);
        if (memWrite) memModel[ba] = memWData;
        else          memRData = modelRd(ba);
        if (logN < 64) begin
          logWr[logN] = memWrite; logAddr[logN] = ba; logData[logN] = memWrite ? memWData : memRData;
          logN++;
        end
        memBeat = 1'b1;
        bcnt = (bcnt + 1) % 8;
      end else memBeat = 1'b0;
    end else begin
      memBeat = 1'b0;
      bcnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input int m, input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int gc, output int lat);
    @(negedge clk);
    reqWrite[m] = wr; reqAddr[m] = a[31:2]; reqWData[m] = wd; reqValid[m] = 1'b1;
    #1;
    while (!reqGrant[m]) begin @(negedge clk); #1; end
    gc = cyc;
    @(negedge clk);
    reqValid[m] = 1'b0;
    lat = 1;
    while (!rspValid[m]) begin @(negedge clk); lat++; end
    rd = rspData[m];
  endtask

  typedef struct packed {
    logic [2:0]  m;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] expD;
    logic [7:0]  beats;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 1'b0, 32'h1004, 32'h0,         32'h5A5A_1004, 8'd8},
    '{3'd1, 1'b0, 32'h1008, 32'h0,         32'h5A5A_1008, 8'd0},
    '{3'd2, 1'b1, 32'h100C, 32'hDEAD_0001, 32'hDEAD_0001, 8'd0},
    '{3'd3, 1'b0, 32'h100C, 32'h0,         32'hDEAD_0001, 8'd0},
    '{3'd4, 1'b1, 32'h2010, 32'hBEEF_0002, 32'hBEEF_0002, 8'd8},
    '{3'd0, 1'b0, 32'h2010, 32'h0,         32'hBEEF_0002, 8'd0},
    '{3'd1, 1'b0, 32'h2014, 32'h0,         32'h5A5A_2014, 8'd0},
    '{3'd2, 1'b0, 32'h101C, 32'h0,         32'h5A5A_101C, 8'd0}
  };

  function automatic string rowReq(input int i);
    case (i)
      0: return "R1 R4";
      1: return "R2 R12";
      2: return "R3";
      3: return "R3";
      4: return "R5";
      5: return "R5";
      6: return "R5";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; total++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d0, d1, d2, d3, d4;
    int g0, g1, g2, g3, g4, l0, l1, l2, l3, l4, nWr;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 memReq", 32'(memReq), 32'd0);
    chk("R1 rspValid", 32'(rspValid), 32'd0);
    chk("R1 reqGrant", 32'(reqGrant), 32'd0);

    // Vector walk, one access at a time
    for (int i = 0; i < 8; i++) begin
      logN = 0;
      access(int'(VEC[i].m), VEC[i].wr, VEC[i].addr, VEC[i].wd, d0, g0, l0);
      chk({rowReq(i), " data"}, d0, VEC[i].expD);
      chk({rowReq(i), " beats"}, 32'(logN), 32'(VEC[i].beats));
      if (VEC[i].beats == 0) chk({rowReq(i), " latency"}, 32'(l0), 32'd1);
    end

    // R7: lowest invalid ways are used, no writeback
    logN = 0;
    access(0, 1'b0, 32'h3000, 0, d0, g0, l0);
    access(0, 1'b0, 32'h4000, 0, d0, g0, l0);
    nWr = 0;
    for (int k = 0; k < logN; k++) if (logWr[k]) nWr++;
    chk("R7 no writeback into free way", 32'(nWr), 32'd0);

    // R6/R7: full set, victimWay=1 selects dirty line 0x2000 for writeback
    victimWay = 2'd1;
    logN = 0;
    access(1, 1'b0, 32'h5000, 0, d0, g0, l0);
    chk("R4 miss data", d0, 32'h5A5A_5000);
    chk("R6 beat count", 32'(logN), 32'd16);
    for (int k = 0; k < 8; k++) begin
      chk("R6 writeback kind", 32'(logWr[k]), 32'd1);
      chk("R6 writeback addr", logAddr[k], 32'h2000 + 32'(4 * k));
      chk("R6 writeback data", logData[k], (k == 4) ? 32'hBEEF_0002 : (32'h5A5A_2000 + 32'(4 * k)));
      chk("R6 fill kind", 32'(logWr[k + 8]), 32'd0);
      chk("R4 fill addr", logAddr[k + 8], 32'h5000 + 32'(4 * k));
    end
    access(2, 1'b0, 32'h2010, 0, d0, g0, l0);
    chk("R6 written-back word refetched", d0, 32'hBEEF_0002);

    // R8/R9: slow memory, hit under miss and a blocked second miss
    memGap = 1'b1;
    fork
      access(3, 1'b0, 32'h6020, 0, d3, g3, l3);
      begin repeat (2) @(negedge clk); access(1, 1'b0, 32'h7020, 0, d1, g1, l1); end
      begin repeat (4) @(negedge clk); access(2, 1'b0, 32'h1008, 0, d2, g2, l2); end
    join
    chk("R9 hit latency during miss", 32'(l2), 32'd1);
    chk("R9 hit granted before miss response", 32'(g2 < g3 + l3), 32'd1);
    chk("R9 hit data", d2, 32'h5A5A_1008);
    chk("R8 second miss waits", 32'(g1 >= g3 + l3), 32'd1);
    chk("R8 first miss data", d3, 32'h5A5A_6020);
    chk("R8 second miss data", d1, 32'h5A5A_7020);

    // R10: simultaneous hits, lowest index first
    fork
      access(4, 1'b0, 32'h100C, 0, d4, g4, l4);
      access(0, 1'b0, 32'h1008, 0, d0, g0, l0);
    join
    chk("R10 master 0 first", 32'(g4 - g0), 32'd1);
    chk("R10 data m4", d4, 32'hDEAD_0001);
    chk("R10 data m0", d0, 32'h5A5A_1008);

    // R11 and R10 among waiting misses
    fork
      access(0, 1'b0, 32'h8040, 0, d0, g0, l0);
      begin repeat (2) @(negedge clk); access(3, 1'b0, 32'hB080, 0, d3, g3, l3); end
      begin repeat (2) @(negedge clk); access(1, 1'b0, 32'hA060, 0, d1, g1, l1); end
      begin repeat (3) @(negedge clk); access(2, 1'b0, 32'h8044, 0, d2, g2, l2); end
    join
    chk("R11 same-line request waits for fill", 32'(g2 >= g0 + l0), 32'd1);
    chk("R11 data after fill", d2, 32'h5A5A_8044);
    chk("R11 served as hit", 32'(l2), 32'd1);
    chk("R10 waiting misses in index order", 32'(g1 < g3), 32'd1);
    chk("R10 miss data m1", d1, 32'h5A5A_A060);
    chk("R10 miss data m3", d3, 32'h5A5A_B080);
    memGap = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule